// File: doc/BRIEF.md
# Touchscreen Converter SPI Responder

This block is the device side of a 12-bit touch and analog converter that sits behind an SPI controller. It works at the level of whole bytes. Each completed byte exchange is signalled by a strobe. The strobe carries the byte the controller shifted in. The block answers with the byte the device returns for that same exchange.

A byte with its top bit set is a command. Its channel field picks one of eight analog inputs. The next exchange samples that channel and returns the upper seven result bits. The exchange after that returns the lower five bits, left-justified. Every later exchange returns zero until another command arrives.

A command is recognised in any exchange, including the trailing ones. Its effect starts with the following exchange. When the controller releases chip select without asking to hold it, the command state is dropped. The X and Y axis channels return fixed stub values. The other six channels read from per-channel input registers.

Top module: `tsc_spi_resp`

## Requirements
- R1: After reset, `resp_valid_o` is 0 and `resp_byte_o` is 0x00.
- R2: `resp_valid_o` is high for exactly the one cycle after each cycle with `xfer_i` high, and low otherwise. `resp_byte_o` holds its value between responses.
- R3: A received byte with bit 7 set is a command. Bits [6:4] of that byte become the selected channel, and the result sequence restarts. The response in the exchange that carries the command still follows the state from before it.
- R4: In the first exchange after a command, the selected channel's 12-bit value v is captured. The response is {1'b0, v[11:5]}.
- R5: In the second exchange after a command, the response is {v[4:0], 3'b000}. Here v is the value captured under R4, even if the channel input has changed since then.
- R6: Once both result bytes are out, every further exchange returns 0x00. A received byte with bit 7 clear changes neither the selected channel nor the sequence.
- R7: The channel codes are 0 temperature 0, 1 Y position, 2 battery, 3 Z1, 4 Z2, 5 X position, 6 microphone and 7 temperature 1. Code 5 always reads 0x000 and code 1 always reads 0xFFF, whatever their input slice holds. Any other code c reads `chan_val_i[12*c +: 12]`.
- R8: A command received during either result exchange or a trailing zero exchange restarts the sequence on the newly selected channel.
- R9: A `cs_end_i` strobe with `hold_i` low discards the command, so later exchanges return 0x00. This takes precedence over a command in the same cycle. With `hold_i` high, the strobe has no effect.
- R10: Before any command, or after a discard under R9, every exchange returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| xfer_i | input | 1 | One-cycle strobe: a byte exchange has completed |
| rx_byte_i | input | 8 | Byte shifted in by the controller in this exchange |
| cs_end_i | input | 1 | One-cycle strobe: chip select released |
| hold_i | input | 1 | Controller keeps the device selected across the release |
| chan_val_i | input | 96 | Eight 12-bit channel values, channel c at bits [12c+11:12c] |
| resp_byte_o | output | 8 | Byte returned for the last exchange |
| resp_valid_o | output | 1 | Response strobe, one cycle after `xfer_i` |

## Verification
Every response is registered once, so its byte and valid strobe appear in the cycle after the `xfer_i` strobe. A command or a discard changes the sequence state at that same edge, so it shapes the response one exchange later. The bench's behavioural model applies the inputs at each rising edge in exactly this way. The outputs are compared against the model on every falling edge, half a cycle after they settle. Sequences are driven both with idle gaps and back to back on consecutive cycles, to show that no extra latency appears.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  localparam int RES_W  = 12;
  localparam int BYTE_W = 8;
  localparam int CH_W   = 3;
  localparam int N_CH   = 1 << CH_W;
  localparam int HI_W   = BYTE_W - 1;
  localparam int LO_W   = RES_W - HI_W;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_HI,
    PH_LO,
    PH_ZERO
  } phase_e;

  localparam logic [CH_W-1:0] CH_Y = CH_W'(1);
  localparam logic [CH_W-1:0] CH_X = CH_W'(5);
endpackage

// File: rtl/tsc_ctrl_track.sv
module tsc_ctrl_track
  import tsc_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                xfer_i,
  input  logic [BYTE_W-1:0]   rx_byte_i,
  input  logic                clr_i,
  output phase_e              phase_o,
  output logic [CH_W-1:0]     chan_o
);
  phase_e          phase_q;
  logic [CH_W-1:0] chan_q;
  logic            is_cmd;

  assign is_cmd = rx_byte_i[BYTE_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      chan_q  <= '0;
    end else if (clr_i) begin
      phase_q <= PH_IDLE;
    end else if (xfer_i) begin
      if (is_cmd) begin
        phase_q <= PH_HI;
        chan_q  <= rx_byte_i[BYTE_W-2 -: CH_W];
      end else begin
        unique case (phase_q)
          PH_HI:   phase_q <= PH_LO;
          PH_LO:   phase_q <= PH_ZERO;
          default: phase_q <= phase_q;
        endcase
      end
    end
  end

  assign phase_o = phase_q;
  assign chan_o  = chan_q;

  // R3
  ctl_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_i && is_cmd && !clr_i |=>
      phase_q == PH_HI && chan_q == $past(rx_byte_i[BYTE_W-2 -: CH_W]));

  // R9
  clr_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> phase_q == PH_IDLE);

  // R6
  noncmd_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_i && !is_cmd && !clr_i && phase_q == PH_ZERO |=>
      phase_q == PH_ZERO && $stable(chan_q));

  // R10
  idle_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q == PH_IDLE && !(xfer_i && is_cmd) |=> phase_q == PH_IDLE);
endmodule

// File: rtl/tsc_chan_mux.sv
module tsc_chan_mux
  import tsc_pkg::*;
#(
  parameter logic [RES_W-1:0] STUB_X = '0,
  parameter logic [RES_W-1:0] STUB_Y = '1
) (
  input  logic [CH_W-1:0]       chan_i,
  input  logic [N_CH*RES_W-1:0] chan_val_i,
  output logic [RES_W-1:0]      sample_o
);
  logic [RES_W-1:0] val_arr [N_CH];

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    if (c == int'(CH_X)) begin : g_x
      assign val_arr[c] = STUB_X;
    end else if (c == int'(CH_Y)) begin : g_y
      assign val_arr[c] = STUB_Y;
    end else begin : g_in
      assign val_arr[c] = chan_val_i[c*RES_W +: RES_W];
    end
  end

  assign sample_o = val_arr[chan_i];
endmodule

// File: rtl/tsc_resp_fmt.sv
module tsc_resp_fmt
  import tsc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              xfer_i,
  input  phase_e            phase_i,
  input  logic [RES_W-1:0]  sample_i,
  output logic [BYTE_W-1:0] resp_byte_o,
  output logic              resp_valid_o
);
  logic [RES_W-1:0]  held_q;
  logic [BYTE_W-1:0] resp_d;

  // response depends only on state before the incoming byte
  always_comb begin
    unique case (phase_i)
      PH_HI:   resp_d = {1'b0, sample_i[RES_W-1 -: HI_W]};
      PH_LO:   resp_d = {held_q[LO_W-1:0], {(BYTE_W-LO_W){1'b0}}};
      default: resp_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q       <= '0;
      resp_byte_o  <= '0;
      resp_valid_o <= 1'b0;
    end else begin
      resp_valid_o <= xfer_i;
      if (xfer_i) begin
        resp_byte_o <= resp_d;
        if (phase_i == PH_HI) held_q <= sample_i;
      end
    end
  end

  // R2
  valid_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_i |=> resp_valid_o);

  // R2
  valid_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xfer_i |=> !resp_valid_o && $stable(resp_byte_o));

  // R4
  hi_msb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_i && phase_i == PH_HI |=> !resp_byte_o[BYTE_W-1]);

  // R5
  lo_pad_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_i && phase_i == PH_LO |=> resp_byte_o[BYTE_W-LO_W-1:0] == '0);

  // R6
  zero_resp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_i && (phase_i == PH_ZERO || phase_i == PH_IDLE) |=> resp_byte_o == '0);
endmodule

// File: rtl/tsc_spi_resp.sv
module tsc_spi_resp
  import tsc_pkg::*;
#(
  parameter logic [RES_W-1:0] STUB_X = '0,
  parameter logic [RES_W-1:0] STUB_Y = '1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  xfer_i,
  input  logic [BYTE_W-1:0]     rx_byte_i,
  input  logic                  cs_end_i,
  input  logic                  hold_i,
  input  logic [N_CH*RES_W-1:0] chan_val_i,
  output logic [BYTE_W-1:0]     resp_byte_o,
  output logic                  resp_valid_o
);
  phase_e           phase;
  logic [CH_W-1:0]  chan;
  logic [RES_W-1:0] sample;
  logic             clr;

  assign clr = cs_end_i & ~hold_i;

  tsc_ctrl_track u_track (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .xfer_i    (xfer_i),
    .rx_byte_i (rx_byte_i),
    .clr_i     (clr),
    .phase_o   (phase),
    .chan_o    (chan)
  );

  tsc_chan_mux #(
    .STUB_X (STUB_X),
    .STUB_Y (STUB_Y)
  ) u_mux (
    .chan_i     (chan),
    .chan_val_i (chan_val_i),
    .sample_o   (sample)
  );

  tsc_resp_fmt u_fmt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .xfer_i       (xfer_i),
    .phase_i      (phase),
    .sample_i     (sample),
    .resp_byte_o  (resp_byte_o),
    .resp_valid_o (resp_valid_o)
  );

  // R9
  hold_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_end_i && hold_i && !xfer_i |=> $stable(phase) && $stable(chan));
endmodule

// File: tb/sim_tsc_spi_resp.sv
`timescale 1ns/1ps
module sim_tsc_spi_resp;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        xfer_i = 1'b0;
  logic [7:0]  rx_byte_i = '0;
  logic        cs_end_i = 1'b0;
  logic        hold_i = 1'b0;
  logic [95:0] chan_val_i;
  logic [7:0]  resp_byte_o;
  logic        resp_valid_o;

  logic [11:0] cv [8];
  for (genvar g = 0; g < 8; g++) begin : g_cv
    assign chan_val_i[g*12 +: 12] = cv[g];
  end

  always #10 clk_i = ~clk_i;

  tsc_spi_resp u0 (.*);

  int checks = 0, fails = 0;
  bit done = 0;
  string ctx = "R1";

  // reference model
  int          m_ph = 0;
  int          m_chan = 0;
  logic [11:0] m_held = '0;
  logic [7:0]  m_byte = '0;
  bit          m_valid = 0;
  string       m_req = "R1";

  function automatic logic [11:0] chan_read(int c);
    if (c == 5) return 12'h000;
    if (c == 1) return 12'hFFF;
    return cv[c];
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_ph <= 0; m_chan <= 0; m_byte <= '0; m_valid <= 0; m_req <= "R1";
    end else begin
      m_valid <= xfer_i;
      if (xfer_i) begin
        logic [11:0] v;
        v = chan_read(m_chan);
        case (m_ph)
          1: begin m_byte <= {1'b0, v[11:5]}; m_held <= v; m_ph <= 2; m_req <= "R4"; end
          2: begin m_byte <= {m_held[4:0], 3'b000}; m_ph <= 3; m_req <= "R5"; end
          3: begin m_byte <= 8'h00; m_req <= "R6"; end
          default: begin m_byte <= 8'h00; m_req <= "R10"; end
        endcase
        if (rx_byte_i[7]) begin m_ph <= 1; m_chan <= int'(rx_byte_i[6:4]); end
      end else m_req <= "R2";
      if (cs_end_i && !hold_i) m_ph <= 0;
    end
  end

  always @(negedge clk_i) if (rst_ni && !done) begin
    checks++;
    if (resp_valid_o !== m_valid || resp_byte_o !== m_byte) begin
      fails++;
      $display("FAIL %s/R2 (%s): valid=%0b byte=%02h expected valid=%0b byte=%02h",
               m_req, ctx, resp_valid_o, resp_byte_o, m_valid, m_byte);
    end
  end

  task automatic xfer(input logic [7:0] b, input int gap = 1);
    @(negedge clk_i); xfer_i = 1'b1; rx_byte_i = b;
    @(negedge clk_i); xfer_i = 1'b0; rx_byte_i = '0;
    repeat (gap - 1) @(negedge clk_i);
  endtask

  task automatic cs_end(input bit hold);
    @(negedge clk_i); cs_end_i = 1'b1; hold_i = hold;
    @(negedge clk_i); cs_end_i = 1'b0; hold_i = 1'b0;
  endtask

  initial begin
    for (int c = 0; c < 8; c++) cv[c] = 12'(16'h0A0 * (c + 1) + c);
    cv[3] = 12'hABC;
    repeat (3) @(negedge clk_i);
    // R1: reset state
    checks++;
    if (resp_valid_o !== 1'b0 || resp_byte_o !== 8'h00) begin
      fails++;
      $display("FAIL R1: valid=%0b byte=%02h expected valid=0 byte=00", resp_valid_o, resp_byte_o);
    end
    rst_ni = 1'b1;
    ctx = "R10"; xfer(8'h00); xfer(8'h3F);
    ctx = "R3";  xfer(8'hB0); xfer(8'h00); xfer(8'h00); xfer(8'h00);
    ctx = "R5";  xfer(8'hB3); xfer(8'h00); cv[3] = 12'h5A5; xfer(8'h00); xfer(8'h00);
    ctx = "R7";  cv[5] = 12'h123; cv[1] = 12'h456;
    xfer(8'hD0); xfer(8'h00); xfer(8'h00);
    xfer(8'h90); xfer(8'h00); xfer(8'h00);
    for (int c = 0; c < 8; c++) begin
      xfer({1'b1, 3'(c), 4'hF}, 2); xfer(8'h00, 3); xfer(8'h00); xfer(8'h00);
    end
    ctx = "R6";  xfer(8'hE0); xfer(8'h00); xfer(8'h00); xfer(8'h7F); xfer(8'h2A); xfer(8'h00);
    ctx = "R8";  xfer(8'hA0); xfer(8'hC0); xfer(8'h80); xfer(8'h00); xfer(8'hF0); xfer(8'h00);
    xfer(8'h00); xfer(8'h00); xfer(8'h30); xfer(8'h00);
    ctx = "R9";  xfer(8'hB0); cs_end(1'b0); xfer(8'h00); xfer(8'h00);
    xfer(8'hB0); cs_end(1'b1); xfer(8'h00); xfer(8'h00);
    xfer(8'hE0); xfer(8'h00);
    @(negedge clk_i); xfer_i = 1'b1; rx_byte_i = 8'hC0; cs_end_i = 1'b1; hold_i = 1'b0;
    @(negedge clk_i); xfer_i = 1'b0; rx_byte_i = '0; cs_end_i = 1'b0;
    xfer(8'h00); xfer(8'h00);
    ctx = "R2";
    @(negedge clk_i); xfer_i = 1'b1; rx_byte_i = 8'hE0;
    @(negedge clk_i); rx_byte_i = 8'h00;
    @(negedge clk_i); rx_byte_i = 8'h00;
    @(negedge clk_i); rx_byte_i = 8'hA0;
    @(negedge clk_i); rx_byte_i = 8'h00;
    @(negedge clk_i); xfer_i = 1'b0; rx_byte_i = '0;
    repeat (4) @(negedge clk_i);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule